// File: doc/BRIEF.md
# Multicast Load/Store Crossbar with Split Byte Routing

This block is the switch between a compute array and its load/store cells. It has 32 operation-cell ports, 16 on the left edge and 16 on the right edge of the array, and 10 load/store ports. Load data moves from the load/store ports to the operation cells. Store data moves from the operation cells to the load/store ports.

Every route comes from a static table of configuration registers, and the data paths themselves are pure multiplexers. One load result can feed any number of operation cells, and one operation cell can feed any number of load/store ports. Each operation cell takes the upper byte and the lower byte of its 16-bit load input from separately chosen load/store ports, so the two halves can come from different memory banks.

The table is written one entry per clock through a small write port. A write that selects a nonexistent load/store cell raises a sticky error flag, and the affected half-word output is held at zero.

Top module: `xbar_mcast`

## Requirements
- R1: After reset, every load selector is idle, so all operation-cell load outputs are zero. Every store route is disabled, so all store data is zero and every store valid is low. The error flag is low.
- R2: Load routing works as follows:
  - Bits 15:8 of an operation cell's load output equal bits 15:8 of the load/store port chosen by its upper selector.
  - Bits 7:0 equal bits 7:0 of the port chosen by its lower selector.
  - The path is combinational, so a change in the load data appears in the same cycle.
- R3: Any number of operation cells may select the same load/store port, and each of them receives that port's data.
- R4: The upper and lower selectors of one operation cell may name different load/store ports, and each half follows its own port.
- R5: A selector value of 15 means idle. It drives zero on its half and does not raise the error flag.
- R6: Writing a load selector value from 10 to 14 has three effects:
  - The error flag goes high after the next rising clock edge.
  - The affected half stays zero.
  - The flag stays high until reset, even after later legal writes.
- R7: Store routing depends on the entry's enable bit:
  - When the enable bit is set, a load/store port's store data equals the chosen operation cell's store data, and its store valid is high.
  - When the enable bit is clear, the port's data is zero and its valid is low.
- R8: Several load/store ports may select the same operation cell, and each of them carries that cell's store data.
- R9: The configuration write port works as follows:
  - With `cfg_store`=0, writing `cfg_addr`=j sets operation cell j's lower selector from `cfg_data[3:0]` and its upper selector from `cfg_data[7:4]`.
  - With `cfg_store`=1, writing `cfg_addr`=i sets load/store port i's operation-cell index from `cfg_data[4:0]` and its enable bit from `cfg_data[5]`.
  - A write takes effect at the rising edge where `cfg_we` is sampled high, and not before.
  - A store write to an address of 10 or more is dropped and changes nothing.
- R10: Operation-cell index k maps to a port as follows:
  - For k from 0 to 15, it is left-edge port k (bits 16k+15:16k of the left buses).
  - For k from 16 to 31, it is right-edge port k-16 (same bit layout on the right buses).
  - This mapping applies to the load configuration address and to the store selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_store | input | 1 | 0 selects the load table, 1 selects the store table |
| cfg_addr | input | 5 | Table entry index |
| cfg_data | input | 8 | Entry value |
| ls_load_data | input | 160 | Load data from the 10 load/store ports, 16 bits each |
| op_left_load | output | 256 | Load data to the 16 left operation cells |
| op_right_load | output | 256 | Load data to the 16 right operation cells |
| op_left_store | input | 256 | Store data from the 16 left operation cells |
| op_right_store | input | 256 | Store data from the 16 right operation cells |
| ls_store_data | output | 160 | Store data to the 10 load/store ports |
| ls_store_vld | output | 10 | Store route enabled and legal, one bit per port |
| cfg_err | output | 1 | Sticky illegal-selector flag |

## Verification
The bench builds the block with its defaults: 16 cells per side, 10 load/store ports and 16-bit data. With 10 ports, a 4-bit selector has both legal values and the illegal codes 10 to 14, so the error path can be reached.

A 32-cell operation space exercises both edge buses. It also places the left/right boundary between indices 15 and 16 inside the 5-bit store selector. Random table writes, which include illegal and idle nibbles, run alongside random data. Periodic resets keep the sticky flag observable more than once.

// File: rtl/xbar_mcast_pkg.sv
package xbar_mcast_pkg;
  localparam int LS_SEL_W = 4;
  localparam int OP_SEL_W = 5;
  localparam int LD_CFG_W = 2 * LS_SEL_W;
  localparam int ST_CFG_W = OP_SEL_W + 1;
  localparam logic [LS_SEL_W-1:0] LS_IDLE = 4'hF;

  // a load selector is illegal when it is neither idle nor an existing port
  function automatic logic ls_sel_bad(input logic [LS_SEL_W-1:0] sel, input int n_ls);
    return (sel != LS_IDLE) && (int'(sel) >= n_ls);
  endfunction

  function automatic logic op_sel_ok(input logic [OP_SEL_W-1:0] sel, input int n_op);
    return int'(sel) < n_op;
  endfunction
endpackage

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs
  import xbar_mcast_pkg::*;
#(
  parameter int N_OP = 32,
  parameter int N_LS = 10,
  parameter int AW   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic                       cfg_store,
  input  logic [AW-1:0]              cfg_addr,
  input  logic [LD_CFG_W-1:0]        cfg_data,
  output logic [N_OP*LD_CFG_W-1:0]   ld_cfg,
  output logic [N_LS*ST_CFG_W-1:0]   st_cfg,
  output logic                       err_set,
  output logic                       cfg_err
);
  logic ld_hit, st_hit, ld_bad, st_bad;

  assign ld_hit = cfg_we && !cfg_store && (int'(cfg_addr) < N_OP);
  assign st_hit = cfg_we && cfg_store && (int'(cfg_addr) < N_LS);
  assign ld_bad = ls_sel_bad(cfg_data[LD_CFG_W-1:LS_SEL_W], N_LS) ||
                  ls_sel_bad(cfg_data[LS_SEL_W-1:0], N_LS);
  assign st_bad = cfg_data[OP_SEL_W] && !op_sel_ok(cfg_data[OP_SEL_W-1:0], N_OP);
  assign err_set = (ld_hit && ld_bad) || (st_hit && st_bad);

  for (genvar j = 0; j < N_OP; j++) begin : g_ld
    logic [LD_CFG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              q <= {LS_IDLE, LS_IDLE};
      else if (ld_hit && cfg_addr == AW'(j))   q <= cfg_data;
    end
    assign ld_cfg[j*LD_CFG_W +: LD_CFG_W] = q;
  end

  for (genvar i = 0; i < N_LS; i++) begin : g_st
    logic [ST_CFG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              q <= '0;
      else if (st_hit && cfg_addr == AW'(i))   q <= cfg_data[ST_CFG_W-1:0];
    end
    assign st_cfg[i*ST_CFG_W +: ST_CFG_W] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cfg_err <= 1'b0;
    else if (err_set) cfg_err <= 1'b1;
  end
endmodule

// File: rtl/xbar_load_mux.sv
module xbar_load_mux
  import xbar_mcast_pkg::*;
#(
  parameter int N_LS = 10,
  parameter int DW   = 16
) (
  input  logic [N_LS*DW-1:0]   ls_data,
  input  logic [LS_SEL_W-1:0]  sel_hi,
  input  logic [LS_SEL_W-1:0]  sel_lo,
  output logic [DW-1:0]        dout,
  output logic                 hi_bad,
  output logic                 lo_bad
);
  localparam int HW = DW / 2;

  always_comb begin
    dout = '0;
    for (int k = 0; k < N_LS; k++) begin
      if (sel_hi == LS_SEL_W'(k)) dout[DW-1:HW] = ls_data[k*DW+HW +: HW];
      if (sel_lo == LS_SEL_W'(k)) dout[HW-1:0]  = ls_data[k*DW +: HW];
    end
  end

  assign hi_bad = ls_sel_bad(sel_hi, N_LS);
  assign lo_bad = ls_sel_bad(sel_lo, N_LS);
endmodule

// File: rtl/xbar_store_mux.sv
module xbar_store_mux
  import xbar_mcast_pkg::*;
#(
  parameter int N_OP = 32,
  parameter int DW   = 16
) (
  input  logic [N_OP*DW-1:0]   op_data,
  input  logic [OP_SEL_W-1:0]  sel,
  input  logic                 en,
  output logic [DW-1:0]        dout,
  output logic                 vld
);
  always_comb begin
    dout = '0;
    for (int k = 0; k < N_OP; k++)
      if (en && sel == OP_SEL_W'(k)) dout = op_data[k*DW +: DW];
  end

  assign vld = en && op_sel_ok(sel, N_OP);
endmodule

// File: rtl/xbar_mcast.sv
module xbar_mcast
  import xbar_mcast_pkg::*;
#(
  parameter int N_SIDE = 16,
  parameter int N_LS   = 10,
  parameter int DW     = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic                          cfg_store,
  input  logic [$clog2(2*N_SIDE)-1:0]   cfg_addr,
  input  logic [LD_CFG_W-1:0]           cfg_data,
  input  logic [N_LS*DW-1:0]            ls_load_data,
  output logic [N_SIDE*DW-1:0]          op_left_load,
  output logic [N_SIDE*DW-1:0]          op_right_load,
  input  logic [N_SIDE*DW-1:0]          op_left_store,
  input  logic [N_SIDE*DW-1:0]          op_right_store,
  output logic [N_LS*DW-1:0]            ls_store_data,
  output logic [N_LS-1:0]               ls_store_vld,
  output logic                          cfg_err
);
  localparam int N_OP = 2 * N_SIDE;
  localparam int AW   = $clog2(N_OP);

  logic [N_OP*LD_CFG_W-1:0] ld_cfg;
  logic [N_LS*ST_CFG_W-1:0] st_cfg;
  logic                     err_set;
  logic [N_OP-1:0]          hi_bad, lo_bad;
  logic [N_OP*DW-1:0]       op_store_all, op_load_all;

  // operation-cell index space: left edge first, right edge above it
  assign op_store_all  = {op_right_store, op_left_store};
  assign op_left_load  = op_load_all[N_SIDE*DW-1:0];
  assign op_right_load = op_load_all[N_OP*DW-1:N_SIDE*DW];

  xbar_cfg_regs #(.N_OP(N_OP), .N_LS(N_LS), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_store(cfg_store),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .ld_cfg(ld_cfg),
    .st_cfg(st_cfg), .err_set(err_set), .cfg_err(cfg_err)
  );

  for (genvar j = 0; j < N_OP; j++) begin : g_ldm
    xbar_load_mux #(.N_LS(N_LS), .DW(DW)) u_ldm (
      .ls_data(ls_load_data),
      .sel_hi(ld_cfg[j*LD_CFG_W+LS_SEL_W +: LS_SEL_W]),
      .sel_lo(ld_cfg[j*LD_CFG_W +: LS_SEL_W]),
      .dout(op_load_all[j*DW +: DW]),
      .hi_bad(hi_bad[j]),
      .lo_bad(lo_bad[j])
    );
  end

  for (genvar i = 0; i < N_LS; i++) begin : g_stm
    xbar_store_mux #(.N_OP(N_OP), .DW(DW)) u_stm (
      .op_data(op_store_all),
      .sel(st_cfg[i*ST_CFG_W +: OP_SEL_W]),
      .en(st_cfg[i*ST_CFG_W+OP_SEL_W]),
      .dout(ls_store_data[i*DW +: DW]),
      .vld(ls_store_vld[i])
    );
  end
endmodule

// File: rtl/xbar_mcast_chk.sv
module xbar_mcast_chk
  import xbar_mcast_pkg::*;
#(
  parameter int N_OP = 32,
  parameter int N_LS = 10,
  parameter int DW   = 16,
  parameter int AW   = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic                     cfg_store,
  input logic [AW-1:0]            cfg_addr,
  input logic [LD_CFG_W-1:0]      cfg_data,
  input logic [N_OP*LD_CFG_W-1:0] ld_cfg,
  input logic [N_OP*DW-1:0]       op_load_all,
  input logic [N_OP-1:0]          hi_bad,
  input logic [N_OP-1:0]          lo_bad,
  input logic                     err_set,
  input logic                     cfg_err,
  input logic [N_LS*DW-1:0]       ls_store_data,
  input logic [N_LS-1:0]          ls_store_vld
);
  localparam int HW = DW / 2;

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  assert_err_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> cfg_err);
  assert_ld_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_store) |=> ld_cfg[$past(cfg_addr)*LD_CFG_W +: LD_CFG_W] == $past(cfg_data));

  for (genvar j = 0; j < N_OP; j++) begin : g_op
    assert_idle_hi_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ld_cfg[j*LD_CFG_W+LS_SEL_W +: LS_SEL_W] == LS_IDLE |-> op_load_all[j*DW+HW +: HW] == '0);
    assert_bad_hi_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hi_bad[j] |-> op_load_all[j*DW+HW +: HW] == '0);
    assert_bad_lo_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lo_bad[j] |-> op_load_all[j*DW +: HW] == '0);
  end

  for (genvar i = 0; i < N_LS; i++) begin : g_ls
    assert_off_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ls_store_vld[i] |-> ls_store_data[i*DW +: DW] == '0);
  end
endmodule

bind xbar_mcast xbar_mcast_chk #(.N_OP(N_OP), .N_LS(N_LS), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_store(cfg_store),
  .cfg_addr(cfg_addr), .cfg_data(cfg_data), .ld_cfg(ld_cfg),
  .op_load_all(op_load_all), .hi_bad(hi_bad), .lo_bad(lo_bad),
  .err_set(err_set), .cfg_err(cfg_err), .ls_store_data(ls_store_data),
  .ls_store_vld(ls_store_vld)
);

// File: tb/xbar_mcast_tb.sv
module xbar_mcast_tb;
  localparam int NS = 16, NL = 10, DW = 16, NO = 2 * NS;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, cfg_store = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic [NL*DW-1:0] ls_load_data = '0;
  logic [NS*DW-1:0] op_left_load, op_right_load;
  logic [NS*DW-1:0] op_left_store = '0, op_right_store = '0;
  logic [NL*DW-1:0] ls_store_data;
  logic [NL-1:0] ls_store_vld;
  logic cfg_err;

  always #4 clk = ~clk;  // 125 MHz

  xbar_mcast u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_store(cfg_store),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .ls_load_data(ls_load_data),
    .op_left_load(op_left_load), .op_right_load(op_right_load),
    .op_left_store(op_left_store), .op_right_store(op_right_store),
    .ls_store_data(ls_store_data), .ls_store_vld(ls_store_vld), .cfg_err(cfg_err)
  );

  int n_tests = 0, n_fail = 0;
  logic [3:0] m_hi [NO];
  logic [3:0] m_lo [NO];
  logic [4:0] m_ss [NL];
  logic       m_se [NL];
  logic       m_err;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int j = 0; j < NO; j++) begin m_hi[j] = 4'hF; m_lo[j] = 4'hF; end
    for (int i = 0; i < NL; i++) begin m_ss[i] = '0; m_se[i] = 1'b0; end
    m_err = 1'b0;
  endtask

  function automatic logic [DW-1:0] exp_load(input int j);
    logic [DW-1:0] r = '0;
    if (m_hi[j] < 4'd10) r[15:8] = ls_load_data[int'(m_hi[j])*DW+8 +: 8];
    if (m_lo[j] < 4'd10) r[7:0]  = ls_load_data[int'(m_lo[j])*DW +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] op_store_of(input int k);
    return (k < NS) ? op_left_store[k*DW +: DW] : op_right_store[(k-NS)*DW +: DW];
  endfunction

  function automatic logic [DW-1:0] act_load(input int j);
    return (j < NS) ? op_left_load[j*DW +: DW] : op_right_load[(j-NS)*DW +: DW];
  endfunction

  task automatic check_all(input string tag);
    for (int j = 0; j < NO; j++) chk({tag, " R2 R10 load"}, 32'(act_load(j)), 32'(exp_load(j)));
    for (int i = 0; i < NL; i++) begin
      chk({tag, " R7 vld"}, 32'(ls_store_vld[i]), 32'(m_se[i]));
      chk({tag, " R7 data"}, 32'(ls_store_data[i*DW +: DW]),
          m_se[i] ? 32'(op_store_of(int'(m_ss[i]))) : 32'd0);
    end
    chk({tag, " R6 err"}, 32'(cfg_err), 32'(m_err));
  endtask

  task automatic rand_data();
    for (int i = 0; i < NL; i++) ls_load_data[i*DW +: DW] = DW'($urandom);
    for (int k = 0; k < NS; k++) begin
      op_left_store[k*DW +: DW]  = DW'($urandom);
      op_right_store[k*DW +: DW] = DW'($urandom);
    end
  endtask

  task automatic cfg_wr(input logic st, input int addr, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_store = st; cfg_addr = 5'(addr); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!st) begin
      m_hi[addr] = d[7:4]; m_lo[addr] = d[3:0];
      if ((d[7:4] >= 4'd10 && d[7:4] != 4'hF) || (d[3:0] >= 4'd10 && d[3:0] != 4'hF)) m_err = 1'b1;
    end else if (addr < NL) begin
      m_ss[addr] = d[4:0]; m_se[addr] = d[5];
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    model_reset();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rand_data();
    #1 check_all("R1 reset");

    // R9: write not visible before the sampling edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_store = 1'b0; cfg_addr = 5'd0; cfg_data = 8'h33;
    #1 chk("R9 before edge", 32'(act_load(0)), 32'd0);
    @(negedge clk); cfg_we = 1'b0; m_hi[0] = 4'd3; m_lo[0] = 4'd3;
    #1 check_all("R9 after edge");

    // R4 split halves from different ports, both edges
    cfg_wr(1'b0, 20, 8'h72);
    cfg_wr(1'b0, 5, 8'h27);
    #1 check_all("R4 split");
    chk("R4 upper", 32'(act_load(20) >> 8), 32'(ls_load_data[7*DW+8 +: 8]));

    // R3 broadcast of port 9
    for (int j = 8; j < 13; j++) cfg_wr(1'b0, j, 8'h99);
    cfg_wr(1'b0, 28, 8'h99);
    rand_data();
    #1 check_all("R3 broadcast");
    chk("R3 right edge", 32'(act_load(28)), 32'(ls_load_data[9*DW +: DW]));

    // R5 idle half, no error
    cfg_wr(1'b0, 3, 8'hF1);
    #1 chk("R5 idle upper", 32'(act_load(3) >> 8), 32'd0);
    chk("R5 no err", 32'(cfg_err), 32'd0);

    // R8 store multicast, R10 edge boundary
    cfg_wr(1'b1, 0, 8'h31);
    cfg_wr(1'b1, 4, 8'h31);
    cfg_wr(1'b1, 9, 8'h31);
    cfg_wr(1'b1, 1, 8'h2F);
    cfg_wr(1'b1, 2, 8'h30);
    #1 check_all("R8 R10 store");
    chk("R10 left 15", 32'(ls_store_data[1*DW +: DW]), 32'(op_right_store[DW-1:0] ^ 16'h0 ^ op_right_store[DW-1:0] ^ op_left_store[15*DW +: DW]));
    chk("R10 right 0", 32'(ls_store_data[2*DW +: DW]), 32'(op_right_store[DW-1:0]));

    // R7 disable one route
    cfg_wr(1'b1, 4, 8'h11);
    #1 check_all("R7 disable");

    // R9 dropped store write
    cfg_wr(1'b1, 12, 8'h23);
    #1 check_all("R9 dropped");

    // R6 illegal selector, sticky
    cfg_wr(1'b0, 6, 8'hC2);
    #1 chk("R6 err set", 32'(cfg_err), 32'd1);
    chk("R6 upper zero", 32'(act_load(6) >> 8), 32'd0);
    cfg_wr(1'b0, 6, 8'h22);
    #1 chk("R6 sticky", 32'(cfg_err), 32'd1);
    check_all("R6 after legal");
    do_reset();
    #1 check_all("R1 R6 cleared");

    // random phase
    for (int it = 0; it < 400; it++) begin
      logic st;
      if (it % 60 == 59) do_reset();
      st = 1'($urandom);
      rand_data();
      cfg_wr(st, st ? int'($urandom % 12) : int'($urandom % NO),
             st ? 8'($urandom % 64) : 8'($urandom));
      #1 check_all("rand");
    end

    finish_run();
  end
endmodule